// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a behavioural model of a synchronous, pipelined memory with a 36-bit common data word. The word is split into four lanes, and each lane holds 8 data bits and 1 parity bit. On every rising clock edge it samples two address strobes, three chip selects, an advance input and the write-control inputs. It sorts each edge into one of these cycles: deselect, begin-read, begin-write, continue-read, suspend-read, continue-write or suspend-write. A 2-bit wrap-around burst counter supplies the low address bits of a burst, in either linear or interleaved order.

Read data passes through one output register. The bus is modelled as a separate read-data port plus a drive-enable output, so no tri-state port is needed. The drive-enable stays low in these cases: while deselected, during any write cycle, and during the first cycle after a read starts from a non-read state. Otherwise it follows an output-enable input with no clock in the path.

The controlling state machine has three states:
- `ST_IDLE`: deselected.
- `ST_READ`: read access in progress.
- `ST_WRITE`: write access in progress.

Its transitions are:
- CY_DESEL: any state to `ST_IDLE`.
- CY_HOLD_IDLE: `ST_IDLE` to `ST_IDLE`.
- CY_BEGIN_RD, CY_CONT_RD, CY_SUSP_RD: any state except idle-hold to `ST_READ`. CY_BEGIN_RD is also taken from `ST_IDLE`.
- CY_BEGIN_WR, CY_CONT_WR, CY_SUSP_WR: to `ST_WRITE`. The continue and suspend forms are taken only from a non-idle state.

Top module: `pbsram_ctrl`

## Requirements
- R1: A strobe that is accepted while the selects are not all active deselects the block, and `rdata_drive` is 0 for the whole next cycle. The selects are all active when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0.
- R2: The processor strobe (`proc_strobe_n`=0) is ignored while `sel_a_n`=1. In that case a controller strobe in the same cycle is still accepted, and an ongoing burst continues.
- R3: An accepted processor strobe always begins a read at `addr`, whatever the write inputs are. It wins when both strobes are low. A write in the same burst takes effect from the next edge on.
- R4: A controller strobe with the processor strobe high, the selects active and a write requested writes at `addr` on that same edge.
- R5: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R6: With `all_wr_n`=1, lane i (bits 9i+8..9i) is written only when `lane_wr_en_n`=0 and `lane_sel_n[i]`=0. All other lanes keep their contents.
- R7: A read issued at edge k places its word on `rdata` after edge k+1.
- R8: On the first cycle after a read begins from the idle or write state, `rdata_drive` is 0 whatever `out_en_n` is.
- R9: `rdata_drive` is 0 during any write cycle, even when `out_en_n`=0.
- R10: `out_en_n` (active low) gates `rdata_drive` combinationally, without waiting for a clock edge.
- R11: With no strobe and `advance_n`=0, the low two address bits step through the burst order. With `burst_linear`=1 the step is a start+n addition mod 4. With `burst_linear`=0 the step is start XOR n.
- R12: With no strobe and `advance_n`=1, the access repeats at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address captured at an accepted strobe |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| burst_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Registered read data |
| rdata_drive | output | 1 | 1 when the block would drive the bus |

## Verification
Two functions can fall in the same cycle:
- A continue-write can arrive while the output register still holds a pending read word. Write blanking must then win over that word.
- A new strobe can arrive in the middle of a burst. The restart must override the advance.

Directed sequences provoke both cases: a processor-strobe read followed at once by a byte write, and a strobe issued during an advancing burst. A long mixed random phase provokes them again. The bench's behavioural model predicts the drive-enable and the data in every clock. Any difference is reported against the requirement under test.

// File: rtl/sram_pkg.sv
package sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } bus_state_e;

    typedef enum logic [2:0] {
        CY_HOLD_IDLE,
        CY_DESEL,
        CY_BEGIN_RD,
        CY_BEGIN_WR,
        CY_CONT_RD,
        CY_SUSP_RD,
        CY_CONT_WR,
        CY_SUSP_WR
    } cycle_e;
endpackage

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
    import sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       advance_n,
    input  logic       sel_a_n,
    input  logic       sel_b,
    input  logic       sel_c_n,
    input  logic       wr_req,
    output cycle_e     cyc,
    output bus_state_e state,
    output logic       load_addr,
    output logic       step_burst,
    output logic       rd_now,
    output logic       wr_now
);
    logic       proc_take;
    logic       ctrl_take;
    logic       chip_on;
    bus_state_e state_nx;

    // Classify the current edge.
    always_comb begin
        proc_take = !proc_strobe_n && !sel_a_n;
        ctrl_take = !ctrl_strobe_n && !proc_take;
        chip_on   = !sel_a_n && sel_b && !sel_c_n;
        if (proc_take || ctrl_take) begin
            if (!chip_on)
                cyc = CY_DESEL;
            else if (proc_take || !wr_req)
                cyc = CY_BEGIN_RD;
            else
                cyc = CY_BEGIN_WR;
        end else if (state == ST_IDLE) begin
            cyc = CY_HOLD_IDLE;
        end else if (wr_req) begin
            cyc = advance_n ? CY_SUSP_WR : CY_CONT_WR;
        end else begin
            cyc = advance_n ? CY_SUSP_RD : CY_CONT_RD;
        end
    end

    // Per-cycle outputs and next state.
    always_comb begin
        load_addr  = 1'b0;
        step_burst = 1'b0;
        rd_now     = 1'b0;
        wr_now     = 1'b0;
        state_nx   = state;
        unique case (cyc)
            CY_HOLD_IDLE: state_nx = ST_IDLE;
            CY_DESEL:     state_nx = ST_IDLE;
            CY_BEGIN_RD: begin
                load_addr = 1'b1; rd_now = 1'b1; state_nx = ST_READ;
            end
            CY_BEGIN_WR: begin
                load_addr = 1'b1; wr_now = 1'b1; state_nx = ST_WRITE;
            end
            CY_CONT_RD: begin
                step_burst = 1'b1; rd_now = 1'b1; state_nx = ST_READ;
            end
            CY_SUSP_RD: begin
                rd_now = 1'b1; state_nx = ST_READ;
            end
            CY_CONT_WR: begin
                step_burst = 1'b1; wr_now = 1'b1; state_nx = ST_WRITE;
            end
            CY_SUSP_WR: begin
                wr_now = 1'b1; state_nx = ST_WRITE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R3
    proc_begins_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !sel_a_n && sel_b && !sel_c_n) |=> (state == ST_READ));

    // R4
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && !ctrl_strobe_n && !sel_a_n && sel_b && !sel_c_n && wr_req)
        |=> (state == ST_WRITE));

    // R1
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((!proc_strobe_n && !sel_a_n) || !ctrl_strobe_n) && !(!sel_a_n && sel_b && !sel_c_n))
        |=> (state == ST_IDLE));
endmodule

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          linear,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);
    logic [AW-1:0] base;
    logic [1:0]    cnt;
    logic [1:0]    cnt_use;
    logic [1:0]    low;

    always_comb begin
        cnt_use  = step ? 2'(cnt + 2'd1) : cnt;
        low      = linear ? 2'(base[1:0] + cnt_use) : (base[1:0] ^ cnt_use);
        eff_addr = load ? addr_in : {base[AW-1:2], low};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            cnt  <= '0;
        end else if (load) begin
            base <= addr_in;
            cnt  <= '0;
        end else begin
            cnt  <= cnt_use;
        end
    end

    // R12
    suspend_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step && $stable(linear)) |-> (eff_addr == $past(eff_addr)));
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_word,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_mask[l]) mem[wr_addr] <= wr_word[l*LANE_W +: LANE_W];
        end
        assign rd_word[l*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
    import sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    advance_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    burst_linear,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int DW = LANES * LANE_W;

    cycle_e          cyc;
    bus_state_e      state;
    logic            load_addr, step_burst, rd_now, wr_now;
    logic            wr_req;
    logic [LANES-1:0] wr_mask;
    logic [AW-1:0]   eff_addr;
    logic [AW-1:0]   rd_addr_q;
    logic [DW-1:0]   rd_word;
    logic            rd_pend;
    logic            out_valid;

    always_comb begin
        wr_req  = !all_wr_n || (!lane_wr_en_n && !(&lane_sel_n));
        if (!wr_now)        wr_mask = '0;
        else if (!all_wr_n) wr_mask = '1;
        else                wr_mask = ~lane_sel_n & {LANES{!lane_wr_en_n}};
    end

    sram_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_req(wr_req), .cyc(cyc), .state(state),
        .load_addr(load_addr), .step_burst(step_burst),
        .rd_now(rd_now), .wr_now(wr_now)
    );

    sram_burst_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .linear(burst_linear),
        .load(load_addr), .step(step_burst),
        .addr_in(addr), .eff_addr(eff_addr)
    );

    sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .wr_mask(wr_mask), .wr_addr(eff_addr), .wr_word(wdata),
        .rd_addr(rd_addr_q), .rd_word(rd_word)
    );

    // Two-stage read: address stage, then output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend   <= 1'b0;
            rd_addr_q <= '0;
            out_valid <= 1'b0;
            rdata     <= '0;
        end else begin
            rd_pend   <= rd_now;
            rd_addr_q <= eff_addr;
            out_valid <= rd_pend;
            if (rd_pend) rdata <= rd_word;
        end
    end

    assign rdata_drive = out_valid && (state == ST_READ) && !out_en_n;

    // R9
    write_blanks_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> !rdata_drive);

    // R8
    first_read_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && state != ST_READ) |=> !rdata_drive);

    // R1
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CY_DESEL) |=> !rdata_drive);
endmodule

// File: tb/pbsram_ctrl_tb.sv
module pbsram_ctrl_tb;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    logic [AW-1:0] addr;
    logic psn, csn, advn, san, sb, scn, gwn, bwen, lin, oen;
    logic [3:0]  lsel;
    logic [35:0] wdata, rdata;
    logic        drive;

    int nchk = 0;
    int nerr = 0;

    // behavioural reference state
    logic [35:0]   m_mem [DEPTH];
    logic [AW-1:0] m_base, m_rdaddr;
    logic [1:0]    m_cnt;
    logic          m_rdpend, m_outvalid;
    logic [35:0]   m_rdata;
    int            m_kind; // 0 idle, 1 read, 2 write

    always #4 clk = ~clk;

    pbsram_ctrl #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strobe_n(psn), .ctrl_strobe_n(csn), .advance_n(advn),
        .sel_a_n(san), .sel_b(sb), .sel_c_n(scn),
        .all_wr_n(gwn), .lane_wr_en_n(bwen), .lane_sel_n(lsel),
        .burst_linear(lin), .out_en_n(oen), .wdata(wdata),
        .rdata(rdata), .rdata_drive(drive)
    );

    function automatic logic [35:0] pat(input int i);
        logic [5:0] v;
        v = 6'(i);
        return {v, ~v, v ^ 6'h2A, 6'(v + 6'd7), 6'(v * 3), 6'(6'd63 - v)};
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        psn = 1; csn = 1; advn = 1; san = 0; sb = 1; scn = 0;
        gwn = 1; bwen = 1; lsel = 4'hF; oen = 0; wdata = '0; addr = '0;
    endtask

    task automatic model_edge();
        logic wract, ps, cs, rd, wr;
        logic [1:0] lo;
        logic [AW-1:0] a;
        wract = !gwn || (!bwen && lsel != 4'hF);
        ps = !psn && !san;
        cs = !csn && !ps;
        rd = 0; wr = 0; a = '0;
        if (ps || cs) begin
            if (!san && sb && !scn) begin
                m_base = addr; m_cnt = 0; a = addr;
                if (!ps && wract) wr = 1; else rd = 1;
            end
        end else if (m_kind != 0) begin
            if (!advn) m_cnt = m_cnt + 2'd1;
            lo = lin ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
            a = {m_base[AW-1:2], lo};
            if (wract) wr = 1; else rd = 1;
        end
        if (m_rdpend) m_rdata = m_mem[m_rdaddr];
        m_outvalid = m_rdpend;
        m_rdpend = rd;
        m_rdaddr = a;
        if (wr) begin
            for (int l = 0; l < 4; l++)
                if (!gwn || (!bwen && !lsel[l])) m_mem[a][9*l +: 9] = wdata[9*l +: 9];
        end
        m_kind = rd ? 1 : (wr ? 2 : 0);
    endtask

    task automatic step(input string tag);
        logic ed;
        model_edge();
        @(posedge clk); #1;
        ed = m_outvalid && (m_kind == 1) && !oen;
        check(tag, 36'(drive), 36'(ed));
        if (ed) check(tag, rdata, m_rdata);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        quiet(); lin = 1; rst_n = 0;
        m_kind = 0; m_cnt = 0; m_base = '0; m_rdaddr = '0;
        m_rdpend = 0; m_outvalid = 0; m_rdata = '0;
        repeat (3) @(negedge clk);
        check("reset", 36'(drive), 36'd0);
        rst_n = 1;

        // R4 / R9: fill memory with controller-strobe global writes
        for (int i = 0; i < DEPTH; i++) begin
            quiet(); csn = 0; gwn = 0; addr = AW'(i); wdata = pat(i);
            step("R4");
        end
        // R8: read begun from write state is blanked for a cycle
        quiet(); csn = 0; addr = 6'd5; step("R8");
        quiet(); step("R7");
        check("R7", rdata, pat(5));
        check("R7", 36'(drive), 36'd1);
        quiet(); step("R12");
        check("R12", rdata, pat(5));

        // R10: output enable acts without a clock
        #1 oen = 1; #1 check("R10", 36'(drive), 36'd0);
        oen = 0; #1 check("R10", 36'(drive), 36'd1);

        // R11 linear burst from 6: 6,7,4,5
        quiet(); psn = 0; addr = 6'd6; step("R11");
        for (int k = 0; k < 4; k++) begin quiet(); advn = 0; step("R11"); end
        check("R11", rdata, pat(5));
        // R11 interleaved burst from 9: 9,8,11,10
        quiet(); csn = 0; sb = 0; step("R1");
        check("R1", 36'(drive), 36'd0);
        quiet(); lin = 0; step("R1");
        quiet(); lin = 0; psn = 0; addr = 6'd9; step("R11");
        for (int k = 0; k < 4; k++) begin quiet(); lin = 0; advn = 0; step("R11"); end
        check("R11", rdata, pat(10));
        lin = 1;

        // R3 / R6: processor-strobe read, then lanes 0 and 2 written
        quiet(); psn = 0; addr = 6'd12; gwn = 0; wdata = '1; step("R3");
        quiet(); bwen = 0; lsel = 4'b1010; wdata = '1; step("R6");
        quiet(); csn = 0; addr = 6'd12; step("R6");
        quiet(); step("R6");
        check("R6", rdata, {pat(12)[35:27], 9'h1FF, pat(12)[17:9], 9'h1FF});

        // R5: global write overrides lane controls
        quiet(); csn = 0; gwn = 0; bwen = 1; lsel = 4'hF; addr = 6'd13; wdata = 36'h123456789;
        step("R5");
        // R3: both strobes low with write inputs -> read only
        quiet(); psn = 0; csn = 0; gwn = 0; addr = 6'd14; wdata = '0; step("R3");
        quiet(); csn = 0; addr = 6'd13; step("R5");
        quiet(); step("R5");
        check("R5", rdata, 36'h123456789);
        quiet(); csn = 0; addr = 6'd14; step("R3");
        quiet(); step("R3");
        check("R3", rdata, pat(14));

        // R2: processor strobe ignored while sel_a_n high; burst continues
        quiet(); psn = 0; addr = 6'd20; step("R2");
        quiet(); step("R2");
        quiet(); psn = 0; san = 1; advn = 0; addr = 6'd40; step("R2");
        quiet(); step("R2");
        check("R2", rdata, pat(21));
        quiet(); psn = 0; csn = 0; san = 1; step("R2");
        check("R2", 36'(drive), 36'd0);

        // mixed random traffic, compared against the model every clock
        for (int n = 0; n < 4000; n++) begin
            quiet();
            psn  = ($urandom % 6) != 0;
            csn  = ($urandom % 5) != 0;
            san  = ($urandom % 10) == 0;
            sb   = ($urandom % 10) != 0;
            scn  = ($urandom % 12) == 0;
            advn = $urandom % 2;
            gwn  = ($urandom % 6) != 0;
            bwen = ($urandom % 3) != 0;
            lsel = 4'($urandom);
            oen  = ($urandom % 8) == 0;
            addr = AW'($urandom);
            wdata = {4'($urandom), 32'($urandom)};
            step("mix");
        end

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule